// File: doc/BRIEF.md
# Port Burst Address Generator

This block produces the word address that one memory port uses on every clock cycle. In any cycle the address can be forced to word zero, taken from an external address bus, advanced by one from the previous cycle's address, or repeated unchanged. The choice is made by three active-low controls: a clear, a strobe and a step enable. The chosen address goes straight to the output in the same cycle, so a clear or a load costs no dead cycle. The address is also captured on the rising edge and becomes the base for the next cycle's step or repeat.

Each memory port gets its own instance. The controls take effect whether or not the port is selected, so the block has no select or byte-lane inputs. A separate asynchronous system reset clears the stored address at power-on. The address width is a parameter, 14 bits by default. A step from the top address wraps to zero.

The per-cycle choice is an enumerated command: `CMD_CLEAR`, `CMD_LOAD`, `CMD_STEP` and `CMD_REPEAT`. The stored address moves from its current value to the value selected by that command on every edge. The only other transition is the asynchronous system reset, which forces the stored address to zero.

Top module: `addr_burst_gen`

## Requirements
- R1: While `clr_n` is 0, `cur_addr` is 0, whatever the other inputs are (`CMD_CLEAR`).
- R2: While `clr_n` is 1 and `strobe_n` is 0, `cur_addr` equals `ext_addr` in that same cycle (`CMD_LOAD`).
- R3: While `clr_n` and `strobe_n` are 1 and `step_n` is 0, `cur_addr` is the previous cycle's `cur_addr` plus one (`CMD_STEP`).
- R4: While `clr_n`, `strobe_n` and `step_n` are all 1, `cur_addr` repeats the previous cycle's `cur_addr`, and `ext_addr` has no effect (`CMD_REPEAT`).
- R5: A step from the all-ones address gives address 0.
- R6: Priority when controls are active together: clear beats load, and load beats step.
- R7: While `rst_n` is 0, and in the first cycle after it rises with all controls at 1, `cur_addr` is 0.
- R8: The address used in a cycle is the base for the next cycle: it carries into a following repeat unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous system reset, active low; clears the stored address |
| ext_addr | input | ADDR_W | External address, used when loading |
| strobe_n | input | 1 | Load the external address, active low |
| step_n | input | 1 | Advance the address by one, active low |
| clr_n | input | 1 | Force the address to word zero, active low |
| cur_addr | output | ADDR_W | Address used by the port in the current cycle |

## Verification
The hardest case to reach from the ports is a command applied to an arbitrary stored base, in particular the all-ones base that must wrap. The bench reaches it with a load cycle that plants every base value of a 4-bit configuration. It then applies every combination of the three controls, each with every external address. A following repeat cycle, with the external address inverted, shows that the result was stored and that the external bus is ignored.

// File: rtl/addr_burst_pkg.sv
package addr_burst_pkg;
    typedef enum logic [1:0] {
        CMD_REPEAT = 2'd0,
        CMD_STEP   = 2'd1,
        CMD_LOAD   = 2'd2,
        CMD_CLEAR  = 2'd3
    } addr_cmd_e;
endpackage

// File: rtl/abg_cmd_decode.sv
module abg_cmd_decode
    import addr_burst_pkg::*;
(
    input  logic      strobe_n,
    input  logic      step_n,
    input  logic      clr_n,
    output addr_cmd_e cmd
);
    // Fixed priority: clear, then load, then step (R6)
    always_comb begin
        if (!clr_n)
            cmd = CMD_CLEAR;
        else if (!strobe_n)
            cmd = CMD_LOAD;
        else if (!step_n)
            cmd = CMD_STEP;
        else
            cmd = CMD_REPEAT;
    end
endmodule

// File: rtl/abg_next_addr.sv
module abg_next_addr
    import addr_burst_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  addr_cmd_e          cmd,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  ext_addr,
    output logic [ADDR_W-1:0]  sel_addr
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (cmd)
            CMD_CLEAR:  sel_addr = '0;
            CMD_LOAD:   sel_addr = ext_addr;
            CMD_STEP:   sel_addr = base + ONE;   // width-limited, wraps
            CMD_REPEAT: sel_addr = base;
            default:    sel_addr = base;
        endcase
    end
endmodule

// File: rtl/abg_addr_reg.sv
module abg_addr_reg #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |-> q == '0); // R7
endmodule

// File: rtl/addr_burst_gen.sv
module addr_burst_gen
    import addr_burst_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              step_n,
    input  logic              clr_n,
    output logic [ADDR_W-1:0] cur_addr
);
    addr_cmd_e         cmd;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] sel_addr;

    abg_cmd_decode u_dec (
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .clr_n    (clr_n),
        .cmd      (cmd)
    );

    abg_next_addr #(.ADDR_W(ADDR_W)) u_next (
        .cmd      (cmd),
        .base     (base_q),
        .ext_addr (ext_addr),
        .sel_addr (sel_addr)
    );

    abg_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sel_addr),
        .q     (base_q)
    );

    assign cur_addr = sel_addr;

    // One edge seen out of reset, so $past below refers to a post-reset cycle
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> cur_addr == '0); // R1
    AST_LOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !strobe_n) |-> cur_addr == ext_addr); // R2
    AST_STEP_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (clr_n && strobe_n && !step_n) |-> cur_addr == ADDR_W'($past(cur_addr) + 1'b1)); // R3
    AST_REPEAT_SAME: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (clr_n && strobe_n && step_n) |-> cur_addr == $past(cur_addr)); // R4
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (clr_n && strobe_n && !step_n && $past(cur_addr) == {ADDR_W{1'b1}}) |-> cur_addr == '0); // R5
endmodule

// File: tb/addr_burst_gen_bench.sv
`timescale 1ns/1ps
module addr_burst_gen_bench;
    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] ext_addr;
    logic          strobe_n, step_n, clr_n;
    logic [AW-1:0] cur_addr;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    addr_burst_gen #(.ADDR_W(AW)) u_addr_burst_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_addr (ext_addr),
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .clr_n    (clr_n),
        .cur_addr (cur_addr)
    );

    task automatic check(input string tag, input logic [AW-1:0] exp);
        checks++;
        if (cur_addr !== exp) begin
            failures++;
            $display("FAIL %s cur_addr=%0d expected=%0d", tag, cur_addr, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog cur_addr=%0d expected=finish", cur_addr);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; strobe_n = 1'b1; step_n = 1'b1; clr_n = 1'b1; ext_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); ext_addr = 4'd9; #1;
        check("R7 in reset", '0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R7 after reset", '0);

        for (int s = 0; s < N; s++) begin
            for (int c = 0; c < 8; c++) begin
                for (int e = 0; e < N; e++) begin
                    logic [AW-1:0] exp;
                    string tag;
                    logic cl, sb, en;
                    // plant base s
                    @(negedge clk);
                    ext_addr = AW'(s); strobe_n = 1'b0; step_n = 1'b1; clr_n = 1'b1; #1;
                    check("R2 load base", AW'(s));
                    // apply control combination c
                    cl = c[2]; sb = c[1]; en = c[0];
                    @(negedge clk);
                    ext_addr = AW'(e); clr_n = cl; strobe_n = sb; step_n = en; #1;
                    if (!cl) begin
                        exp = '0;
                        tag = (!sb || !en) ? "R6 clear wins" : "R1 clear";
                    end else if (!sb) begin
                        exp = AW'(e);
                        tag = (!en) ? "R6 load beats step" : "R2 load";
                    end else if (!en) begin
                        exp = AW'(s + 1);
                        tag = (s == N - 1) ? "R5 wrap" : "R3 step";
                    end else begin
                        exp = AW'(s);
                        tag = "R4 repeat ignores ext";
                    end
                    check(tag, exp);
                    // repeat with inverted bus: result must have been stored
                    @(negedge clk);
                    ext_addr = ~AW'(e); strobe_n = 1'b1; step_n = 1'b1; clr_n = 1'b1; #1;
                    check("R8 carry into repeat", exp);
                end
            end
        end

        // asynchronous system reset in mid-run
        @(negedge clk);
        ext_addr = 4'd11; strobe_n = 1'b0; #1;
        check("R2 load before reset", 4'd11);
        @(negedge clk);
        strobe_n = 1'b1; #1;
        rst_n = 1'b0; #0.5;
        check("R7 async clear", '0);
        @(negedge clk); rst_n = 1'b1; #1;
        check("R7 released", '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule